// File: doc/BRIEF.md
# Two-Level Radix Translation Walker

This block turns a data effective address into a physical address by walking a two-level radix tree held in memory. A request carries the effective address, a load/store flag and the access length in bytes. The walker reads the directory entry, then the leaf entry, and returns the physical address together with the twelve flag bits of the leaf. If either level has no usable entry, it returns a not-found fault and the address that failed. Permission checks, caching of translations and the data path sit outside this block.

Pages are 4 KB. The tree covers a 2 GB effective space: a 1024-entry directory, each entry pointing to a table of 512 leaves. Entries are 64-bit words stored most-significant byte first, so every word read back is byte-reversed before decoding. If an access runs past the end of its page, the walker also translates the following page. A failure on that second page is reported at the first byte of the second page.

All three data interfaces use valid/ready:
- **Request:** accepted on a cycle with `req_valid` and `req_ready` both high. `req_ready` is high only while no walk is in flight.
- **Memory read address:** `mem_req_valid` holds its address unchanged until `mem_req_ready` is seen. Each accepted read must get exactly one `mem_rsp_valid` beat. The walker takes that beat in any cycle, so the response channel has no ready.
- **Result:** the result holds every field until `res_ready`.

`root_ptr` is a plain control input and must stay stable during a walk.

Top module: `radix_walker`

## Requirements
- R1: `req_ready` is 1 only when no walk is in flight. A request is taken when `req_valid` and `req_ready` are both 1, and `req_ready` is 0 in the next cycle. Each request produces exactly one result. After `res_ready` takes that result, `res_valid` drops and `req_ready` returns to 1.
- R2: The page number is EA >> 12, and only its index bits are used, so EA bits above them have no effect. The first memory read address is (root_ptr & 0x00FFFFFFFFFFFF00) + 8 × (((EA >> 12) >> 9) & (2^root_ptr[4:0] − 1) & 0x3FF).
- R3: Each 64-bit word returned on `mem_rsp_data` is byte-reversed (byte 0 swapped with byte 7, and so on) before any field is decoded.
- R4: A directory entry with bit 63 = 1 and bit 62 = 0 is usable. Its table base is entry & 0x00FFFFFFFFFFFF00 and its bits [4:0] give n, the log2 entry count of the table. The second read address is base + 8 × ((EA >> 12) & (2^n − 1) & 0x1FF).
- R5: A leaf entry with bit 63 = 1 and bit 62 = 1 is usable. Then `res_fault` = 0, `res_pa` = (entry & 0x00FFFFFFFFFFF000) | EA[11:0], and `res_flags` = entry[11:0].
- R6: Any of the following gives `res_fault` = 1 with `res_fault_addr` = EA, and no further read is issued:
  - the directory entry has bit 63 = 0;
  - the directory entry has bit 62 = 1;
  - the leaf entry lacks bit 63 or bit 62, including an all-zero word.
- R7: An access crosses its page when EA[11:0] + `req_len` > 4096. On a crossing, the walker translates page number + 1 after the first page succeeds, and `res_crossed` = 1. If that second walk succeeds, `res_pa_next` = its page base and `res_flags_next` = its flags. If it fails, `res_fault_addr` = (page number + 1) << 12. An access ending exactly at the page end does not cross.
- R8: While `mem_req_valid` = 1 and `mem_req_ready` = 0, the read request and its address hold. While `res_valid` = 1 and `res_ready` = 0, every result field holds.
- R9: After reset, `req_ready` = 1, `mem_req_valid` = 0 and `res_valid` = 0.
- R10: `res_store` equals the `req_store` value of the request that the result answers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| root_ptr | input | 64 | Directory base ORed with log2 directory size in bits [4:0] |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Walker idle, request may be taken |
| req_ea | input | 64 | Effective address to translate |
| req_len | input | 4 | Access length in bytes |
| req_store | input | 1 | 1 for a store, 0 for a load |
| mem_req_valid | output | 1 | Memory read request valid |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 64 | Byte address of the 64-bit entry |
| mem_rsp_valid | input | 1 | Read data beat |
| mem_rsp_data | input | 64 | Raw entry word as stored |
| res_valid | output | 1 | Result valid |
| res_ready | input | 1 | Result consumer ready |
| res_pa | output | 64 | Physical address of the first byte |
| res_flags | output | 12 | Flag bits of the first page's leaf |
| res_crossed | output | 1 | Access spans two pages |
| res_pa_next | output | 64 | Page base of the second page |
| res_flags_next | output | 12 | Flag bits of the second page's leaf |
| res_fault | output | 1 | Not-found fault |
| res_fault_addr | output | 64 | Address reported for the fault |
| res_store | output | 1 | Load/store flag of the answered request |

## Verification
Directed walks place entries in a small memory model and compare the read addresses and results against hand-computed values.

- **Both levels and the index masks:** separate directory slots with different leaf tables, an address with high bits set, a reduced root size field and a 256-entry leaf table each isolate one part of the index arithmetic.
- **Decode rules:** entries with the valid bit clear, the leaf bit misplaced or all zero each hit one rule, and the read count shows whether the walk stopped early.
- **Page crossing:** accesses ending exactly at a page end, crossing into an unmapped page and crossing into a mapped page separate the crossing test from the reported fault address.
- **Back-pressure:** throttled memory ready and a held result expose any drift on the handshakes.

// File: rtl/rw_pkg.sv
`timescale 1ns/1ps
package rw_pkg;

  localparam int unsigned ENT_W = 64;
  localparam int unsigned V_BIT = 63;
  localparam int unsigned L_BIT = 62;
  localparam logic [ENT_W-1:0] TABLE_BASE_MASK = 64'h00FF_FFFF_FFFF_FF00;
  localparam logic [ENT_W-1:0] PAGE_BASE_MASK  = 64'h00FF_FFFF_FFFF_F000;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DIR_RD,
    ST_DIR_WT,
    ST_LEAF_RD,
    ST_LEAF_WT,
    ST_DONE
  } walk_state_e;

  typedef struct packed {
    logic             ok;
    logic [ENT_W-1:0] next_base;
    logic [4:0]       next_bits;
  } dir_info_t;

  typedef struct packed {
    logic             ok;
    logic [ENT_W-1:0] page_base;
    logic [11:0]      flags;
  } leaf_info_t;

  function automatic logic [ENT_W-1:0] byte_rev(input logic [ENT_W-1:0] w);
    logic [ENT_W-1:0] r;
    for (int b = 0; b < ENT_W / 8; b++) begin
      r[8*b +: 8] = w[8*(ENT_W/8-1-b) +: 8];
    end
    return r;
  endfunction

endpackage

// File: rtl/rw_entry_decode.sv
`timescale 1ns/1ps
module rw_entry_decode
  import rw_pkg::*;
(
  input  logic [ENT_W-1:0] raw,
  output dir_info_t        dir_o,
  output leaf_info_t       leaf_o
);

  logic [ENT_W-1:0] word;

  always_comb begin
    word = byte_rev(raw);

    dir_o.ok        = word[V_BIT] & ~word[L_BIT];
    dir_o.next_base = word & TABLE_BASE_MASK;
    dir_o.next_bits = word[4:0];

    leaf_o.ok        = word[V_BIT] & word[L_BIT];
    leaf_o.page_base = word & PAGE_BASE_MASK;
    leaf_o.flags     = word[11:0];
  end

endmodule

// File: rtl/rw_index_gen.sv
`timescale 1ns/1ps
module rw_index_gen
  import rw_pkg::*;
#(
  parameter int unsigned PAGE_BITS = 12,
  parameter int unsigned LEAF_BITS = 9,
  parameter int unsigned DIR_BITS  = 10,
  localparam int unsigned PN_W     = ENT_W - PAGE_BITS
) (
  input  logic [ENT_W-1:0] root_ptr,
  input  logic [PN_W-1:0]  pn,
  input  logic [ENT_W-1:0] leaf_base,
  input  logic [4:0]       leaf_bits,
  output logic [ENT_W-1:0] dir_addr,
  output logic [ENT_W-1:0] leaf_addr
);

  localparam logic [ENT_W-1:0] DIR_SPAN  = (64'd1 << DIR_BITS) - 64'd1;
  localparam logic [ENT_W-1:0] LEAF_SPAN = (64'd1 << LEAF_BITS) - 64'd1;
  localparam int unsigned      ENT_SHIFT = 3;

  logic [ENT_W-1:0] pn_ext;
  logic [ENT_W-1:0] root_base;
  logic [ENT_W-1:0] dir_mask;
  logic [ENT_W-1:0] leaf_mask;
  logic [ENT_W-1:0] dir_idx;
  logic [ENT_W-1:0] leaf_idx;

  always_comb begin
    pn_ext    = ENT_W'(pn);
    root_base = root_ptr & TABLE_BASE_MASK;
    dir_mask  = ~({ENT_W{1'b1}} << root_ptr[4:0]) & DIR_SPAN;
    leaf_mask = ~({ENT_W{1'b1}} << leaf_bits) & LEAF_SPAN;
    dir_idx   = (pn_ext >> LEAF_BITS) & dir_mask;
    leaf_idx  = pn_ext & leaf_mask;
    dir_addr  = root_base + (dir_idx << ENT_SHIFT);
    leaf_addr = leaf_base + (leaf_idx << ENT_SHIFT);
  end

endmodule

// File: rtl/rw_span_check.sv
`timescale 1ns/1ps
module rw_span_check #(
  parameter int unsigned PAGE_BITS = 12,
  parameter int unsigned LEN_W     = 4
) (
  input  logic [PAGE_BITS-1:0] offset,
  input  logic [LEN_W-1:0]     len,
  output logic                 crosses
);

  localparam int unsigned OFF_W     = PAGE_BITS + 1;
  localparam int unsigned PAGE_SIZE = 1 << PAGE_BITS;

  logic [OFF_W-1:0] end_pos;

  always_comb begin
    end_pos = {1'b0, offset} + OFF_W'(len);
    crosses = end_pos > OFF_W'(PAGE_SIZE);
  end

endmodule

// File: rtl/radix_walker.sv
`timescale 1ns/1ps
module radix_walker
  import rw_pkg::*;
#(
  parameter int unsigned PAGE_BITS = 12,
  parameter int unsigned LEAF_BITS = 9,
  parameter int unsigned DIR_BITS  = 10,
  parameter int unsigned LEN_W     = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [63:0] root_ptr,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [63:0] req_ea,
  input  logic [LEN_W-1:0] req_len,
  input  logic        req_store,
  output logic        mem_req_valid,
  input  logic        mem_req_ready,
  output logic [63:0] mem_req_addr,
  input  logic        mem_rsp_valid,
  input  logic [63:0] mem_rsp_data,
  output logic        res_valid,
  input  logic        res_ready,
  output logic [63:0] res_pa,
  output logic [11:0] res_flags,
  output logic        res_crossed,
  output logic [63:0] res_pa_next,
  output logic [11:0] res_flags_next,
  output logic        res_fault,
  output logic [63:0] res_fault_addr,
  output logic        res_store
);

  localparam int unsigned PN_W = ENT_W - PAGE_BITS;

  walk_state_e       state;
  logic [ENT_W-1:0]  ea_q;
  logic              store_q;
  logic              cross_q;
  logic              second_q;
  logic [PN_W-1:0]   pn_q;
  logic [ENT_W-1:0]  leaf_base_q;
  logic [4:0]        leaf_bits_q;
  logic [ENT_W-1:0]  page_q;
  logic [11:0]       flags_q;
  logic [ENT_W-1:0]  page2_q;
  logic [11:0]       flags2_q;
  logic              fault_q;
  logic [ENT_W-1:0]  fault_addr_q;

  logic              cross_now;
  logic [ENT_W-1:0]  dir_addr;
  logic [ENT_W-1:0]  leaf_addr;
  logic [ENT_W-1:0]  fault_addr_now;
  dir_info_t         dir_i;
  leaf_info_t        leaf_i;

  rw_span_check #(
    .PAGE_BITS (PAGE_BITS),
    .LEN_W     (LEN_W)
  ) u_span (
    .offset  (req_ea[PAGE_BITS-1:0]),
    .len     (req_len),
    .crosses (cross_now)
  );

  rw_index_gen #(
    .PAGE_BITS (PAGE_BITS),
    .LEAF_BITS (LEAF_BITS),
    .DIR_BITS  (DIR_BITS)
  ) u_index (
    .root_ptr  (root_ptr),
    .pn        (pn_q),
    .leaf_base (leaf_base_q),
    .leaf_bits (leaf_bits_q),
    .dir_addr  (dir_addr),
    .leaf_addr (leaf_addr)
  );

  rw_entry_decode u_decode (
    .raw    (mem_rsp_data),
    .dir_o  (dir_i),
    .leaf_o (leaf_i)
  );

  // First page faults at the access start, the second page at its own base.
  assign fault_addr_now = second_q ? {pn_q, {PAGE_BITS{1'b0}}} : ea_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= ST_IDLE;
      ea_q         <= '0;
      store_q      <= 1'b0;
      cross_q      <= 1'b0;
      second_q     <= 1'b0;
      pn_q         <= '0;
      leaf_base_q  <= '0;
      leaf_bits_q  <= '0;
      page_q       <= '0;
      flags_q      <= '0;
      page2_q      <= '0;
      flags2_q     <= '0;
      fault_q      <= 1'b0;
      fault_addr_q <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (req_valid) begin
            ea_q         <= req_ea;
            store_q      <= req_store;
            cross_q      <= cross_now;
            second_q     <= 1'b0;
            pn_q         <= req_ea[ENT_W-1:PAGE_BITS];
            page_q       <= '0;
            flags_q      <= '0;
            page2_q      <= '0;
            flags2_q     <= '0;
            fault_q      <= 1'b0;
            fault_addr_q <= '0;
            state        <= ST_DIR_RD;
          end
        end
        ST_DIR_RD: begin
          if (mem_req_ready) state <= ST_DIR_WT;
        end
        ST_DIR_WT: begin
          if (mem_rsp_valid) begin
            if (dir_i.ok) begin
              leaf_base_q <= dir_i.next_base;
              leaf_bits_q <= dir_i.next_bits;
              state       <= ST_LEAF_RD;
            end else begin
              fault_q      <= 1'b1;
              fault_addr_q <= fault_addr_now;
              state        <= ST_DONE;
            end
          end
        end
        ST_LEAF_RD: begin
          if (mem_req_ready) state <= ST_LEAF_WT;
        end
        ST_LEAF_WT: begin
          if (mem_rsp_valid) begin
            if (!leaf_i.ok) begin
              fault_q      <= 1'b1;
              fault_addr_q <= fault_addr_now;
              state        <= ST_DONE;
            end else if (!second_q) begin
              page_q  <= leaf_i.page_base;
              flags_q <= leaf_i.flags;
              if (cross_q) begin
                second_q <= 1'b1;
                pn_q     <= pn_q + PN_W'(1);
                state    <= ST_DIR_RD;
              end else begin
                state <= ST_DONE;
              end
            end else begin
              page2_q  <= leaf_i.page_base;
              flags2_q <= leaf_i.flags;
              state    <= ST_DONE;
            end
          end
        end
        ST_DONE: begin
          if (res_ready) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    req_ready      = (state == ST_IDLE);
    mem_req_valid  = (state == ST_DIR_RD) || (state == ST_LEAF_RD);
    mem_req_addr   = (state == ST_LEAF_RD) ? leaf_addr : dir_addr;
    res_valid      = (state == ST_DONE);
    res_pa         = page_q | {{PN_W{1'b0}}, ea_q[PAGE_BITS-1:0]};
    res_flags      = flags_q;
    res_crossed    = cross_q;
    res_pa_next    = page2_q;
    res_flags_next = flags2_q;
    res_fault      = fault_q;
    res_fault_addr = fault_addr_q;
    res_store      = store_q;
  end

endmodule

// File: rtl/rw_walk_checker.sv
`timescale 1ns/1ps
module rw_walk_checker #(
  parameter int unsigned PAGE_BITS = 12
) (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic [63:0] req_ea,
  input logic        req_store,
  input logic        mem_req_valid,
  input logic        mem_req_ready,
  input logic [63:0] mem_req_addr,
  input logic        res_valid,
  input logic        res_ready,
  input logic [63:0] res_pa,
  input logic        res_crossed,
  input logic        res_fault,
  input logic [63:0] res_fault_addr,
  input logic        res_store
);

  logic [63:0] ea_seen;
  logic        store_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ea_seen    <= '0;
      store_seen <= 1'b0;
    end else if (req_valid && req_ready) begin
      ea_seen    <= req_ea;
      store_seen <= req_store;
    end
  end

  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready); // R1

  AST_PHASES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({req_ready, mem_req_valid, res_valid}) <= 1); // R1

  AST_MEM_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)); // R8

  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_pa) && $stable(res_fault)
                               && $stable(res_fault_addr) && $stable(res_crossed)); // R8

  AST_ENTRY_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> mem_req_addr[2:0] == 3'b000); // R2

  AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_fault |-> res_pa[PAGE_BITS-1:0] == ea_seen[PAGE_BITS-1:0]); // R5

  AST_FAULT_AT_EA: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_fault && !res_crossed |-> res_fault_addr == ea_seen); // R6

  AST_NEXT_PAGE_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_fault && res_fault_addr != ea_seen
      |-> res_crossed && res_fault_addr[PAGE_BITS-1:0] == '0); // R7

  AST_STORE_ECHO: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> res_store == store_seen); // R10

endmodule

bind radix_walker rw_walk_checker #(.PAGE_BITS(PAGE_BITS)) u_walk_checker (
  .clk            (clk),
  .rst_n          (rst_n),
  .req_valid      (req_valid),
  .req_ready      (req_ready),
  .req_ea         (req_ea),
  .req_store      (req_store),
  .mem_req_valid  (mem_req_valid),
  .mem_req_ready  (mem_req_ready),
  .mem_req_addr   (mem_req_addr),
  .res_valid      (res_valid),
  .res_ready      (res_ready),
  .res_pa         (res_pa),
  .res_crossed    (res_crossed),
  .res_fault      (res_fault),
  .res_fault_addr (res_fault_addr),
  .res_store      (res_store)
);

// File: tb/test_radix_walker.sv
`timescale 1ns/1ps
module test_radix_walker;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] root_ptr = 64'h100A;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [63:0] req_ea = '0;
  logic [3:0]  req_len = '0;
  logic        req_store = 1'b0;
  logic        mem_req_valid;
  logic        mem_req_ready;
  logic [63:0] mem_req_addr;
  logic        mem_rsp_valid;
  logic [63:0] mem_rsp_data;
  logic        res_valid;
  logic        res_ready = 1'b0;
  logic [63:0] res_pa;
  logic [11:0] res_flags;
  logic        res_crossed;
  logic [63:0] res_pa_next;
  logic [11:0] res_flags_next;
  logic        res_fault;
  logic [63:0] res_fault_addr;
  logic        res_store;

  always #5 clk = ~clk;

  radix_walker i_radix_walker (
    .clk(clk), .rst_n(rst_n), .root_ptr(root_ptr),
    .req_valid(req_valid), .req_ready(req_ready), .req_ea(req_ea),
    .req_len(req_len), .req_store(req_store),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data),
    .res_valid(res_valid), .res_ready(res_ready), .res_pa(res_pa),
    .res_flags(res_flags), .res_crossed(res_crossed),
    .res_pa_next(res_pa_next), .res_flags_next(res_flags_next),
    .res_fault(res_fault), .res_fault_addr(res_fault_addr),
    .res_store(res_store)
  );

  // Memory model: 32 KB of 64-bit words, one-cycle read latency.
  logic [63:0] mem [0:4095];
  logic [63:0] rd_log [0:15];
  logic [31:0] rd_cnt;
  logic [1:0]  stall_ph;
  logic        stall_en = 1'b0;

  assign mem_req_ready = !stall_en || stall_ph[0];

  always @(posedge clk) begin
    if (!rst_n) begin
      mem_rsp_valid <= 1'b0;
      mem_rsp_data  <= '0;
      rd_cnt        <= '0;
      stall_ph      <= '0;
    end else begin
      stall_ph      <= stall_ph + 2'd1;
      mem_rsp_valid <= mem_req_valid && mem_req_ready;
      if (mem_req_valid && mem_req_ready) begin
        mem_rsp_data        <= mem[mem_req_addr[14:3]];
        rd_log[rd_cnt[3:0]] <= mem_req_addr;
        rd_cnt              <= rd_cnt + 32'd1;
      end
    end
  end

  int n_chk = 0;
  int n_bad = 0;

  task automatic chk(input string rq, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  function automatic logic [63:0] to_stored(input logic [63:0] v);
    logic [63:0] r;
    for (int b = 0; b < 8; b++) r[8*b +: 8] = v[8*(7-b) +: 8];
    return r;
  endfunction

  task automatic put_entry(input logic [63:0] addr, input logic [63:0] val);
    mem[addr[14:3]] = to_stored(val);
  endtask

  // Results of the last walk
  logic        w_fault, w_cross, w_store;
  logic [63:0] w_pa, w_fa, w_pan, w_a0, w_a1;
  logic [11:0] w_flags, w_fln;
  int          w_reads;

  task automatic walk(input logic [63:0] ea, input logic [3:0] len,
                      input logic st, input int hold);
    logic [31:0] base;
    int t;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    base      = rd_cnt;
    req_valid = 1'b1;
    req_ea    = ea;
    req_len   = len;
    req_store = st;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R1", "busy after accept", {63'd0, req_ready}, 64'd0);
    t = 0;
    while (!res_valid && t < 500) begin
      @(negedge clk);
      t++;
    end
    if (!res_valid) chk("R1", "result timeout", 64'd0, 64'd1);
    w_fault = res_fault;   w_fa = res_fault_addr;  w_pa = res_pa;
    w_flags = res_flags;   w_cross = res_crossed;  w_pan = res_pa_next;
    w_fln = res_flags_next; w_store = res_store;
    w_reads = int'(rd_cnt - base);
    w_a0 = rd_log[base[3:0]];
    w_a1 = rd_log[base[3:0] + 4'd1];
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      chk("R8", "result held valid", {63'd0, res_valid}, 64'd1);
      chk("R8", "result held pa", res_pa, w_pa);
      chk("R8", "result held fault", {63'd0, res_fault}, {63'd0, w_fault});
    end
    res_ready = 1'b1;
    @(negedge clk);
    res_ready = 1'b0;
    chk("R1", "valid drops after take", {63'd0, res_valid}, 64'd0);
    chk("R1", "ready back after take", {63'd0, req_ready}, 64'd1);
  endtask

  task automatic t_reset;
    chk("R9", "req_ready", {63'd0, req_ready}, 64'd1);
    chk("R9", "mem_req_valid", {63'd0, mem_req_valid}, 64'd0);
    chk("R9", "res_valid", {63'd0, res_valid}, 64'd0);
  endtask

  task automatic t_empty_dir;
    walk(64'h0112_3000, 4'd8, 1'b0, 0);
    chk("R6", "fault", {63'd0, w_fault}, 64'd1);
    chk("R6", "fault addr", w_fa, 64'h0112_3000);
    chk("R6", "reads", 64'(w_reads), 64'd1);
    chk("R2", "dir addr", w_a0, 64'h1040);
  endtask

  task automatic t_basic;
    put_entry(64'h1000, 64'h8000_0000_0000_4009);
    put_entry(64'h4920, 64'hC0AB_0000_0012_3186);
    walk(64'h0012_4108, 4'd8, 1'b0, 0);
    chk("R5", "fault", {63'd0, w_fault}, 64'd0);
    chk("R5", "pa", w_pa, 64'h00AB_0000_0012_3108);
    chk("R5", "flags", {52'd0, w_flags}, 64'h186);
    chk("R3", "reads", 64'(w_reads), 64'd2);
    chk("R2", "dir addr", w_a0, 64'h1000);
    chk("R4", "leaf addr", w_a1, 64'h4920);
    chk("R7", "no cross", {63'd0, w_cross}, 64'd0);
    chk("R10", "load flag", {63'd0, w_store}, 64'd0);
  endtask

  task automatic t_other_slot;
    put_entry(64'h1040, 64'h8000_0000_0000_5009);
    put_entry(64'h5920, 64'hC000_0000_0077_7006);
    walk(64'h0112_4010, 4'd8, 1'b1, 0);
    chk("R2", "dir addr slot 8", w_a0, 64'h1040);
    chk("R4", "leaf addr", w_a1, 64'h5920);
    chk("R5", "pa", w_pa, 64'h0077_7010);
    chk("R5", "flags", {52'd0, w_flags}, 64'h006);
    chk("R10", "store flag", {63'd0, w_store}, 64'd1);
  endtask

  task automatic t_high_bits;
    walk(64'hFF00_0000_8012_4108, 4'd8, 1'b0, 0);
    chk("R2", "high EA bits ignored dir", w_a0, 64'h1000);
    chk("R2", "high EA bits ignored pa", w_pa, 64'h00AB_0000_0012_3108);
  endtask

  task automatic t_bad_entries;
    put_entry(64'h1018, 64'h0000_0000_0000_6009);
    walk(64'h0060_0000, 4'd8, 1'b0, 0);
    chk("R6", "dir invalid fault", {63'd0, w_fault}, 64'd1);
    chk("R6", "dir invalid reads", 64'(w_reads), 64'd1);
    put_entry(64'h1020, 64'hC000_0000_0000_6009);
    walk(64'h0080_0000, 4'd8, 1'b0, 0);
    chk("R6", "dir leaf-bit fault", {63'd0, w_fault}, 64'd1);
    chk("R6", "dir leaf-bit reads", 64'(w_reads), 64'd1);
    put_entry(64'h1008, 64'h8000_0000_0000_6009);
    put_entry(64'h6008, 64'h8000_0000_0099_9186);
    walk(64'h0020_1010, 4'd8, 1'b0, 0);
    chk("R6", "leaf no leaf-bit fault", {63'd0, w_fault}, 64'd1);
    chk("R6", "leaf fault addr", w_fa, 64'h0020_1010);
    chk("R6", "leaf reads", 64'(w_reads), 64'd2);
    walk(64'h0020_2000, 4'd8, 1'b0, 0);
    chk("R6", "zero leaf fault", {63'd0, w_fault}, 64'd1);
    chk("R4", "zero leaf addr", w_a1, 64'h6010);
  endtask

  task automatic t_crossing;
    put_entry(64'h6CF8, 64'hC000_0000_0000_7186);
    walk(64'h0039_FFF8, 4'd8, 1'b0, 0);
    chk("R7", "exact end no cross", {63'd0, w_cross}, 64'd0);
    chk("R7", "exact end reads", 64'(w_reads), 64'd2);
    chk("R5", "exact end pa", w_pa, 64'h7FF8);
    walk(64'h0039_FFFD, 4'd8, 1'b0, 0);
    chk("R7", "cross flag", {63'd0, w_cross}, 64'd1);
    chk("R7", "next page fault", {63'd0, w_fault}, 64'd1);
    chk("R7", "next page fault addr", w_fa, 64'h003A_0000);
    chk("R7", "cross reads", 64'(w_reads), 64'd4);
    put_entry(64'h6D00, 64'hC000_0000_0000_8085);
    walk(64'h0039_FFFD, 4'd8, 1'b0, 0);
    chk("R7", "cross ok fault", {63'd0, w_fault}, 64'd0);
    chk("R7", "cross ok pa", w_pa, 64'h7FFD);
    chk("R7", "cross ok pa_next", w_pan, 64'h8000);
    chk("R7", "cross ok flags_next", {52'd0, w_fln}, 64'h085);
  endtask

  task automatic t_leaf_size;
    put_entry(64'h1010, 64'h8000_0000_0000_7008);
    put_entry(64'h77A8, 64'hC000_0000_00AB_C0A5);
    walk(64'h005F_5234, 4'd4, 1'b0, 0);
    chk("R4", "small table leaf addr", w_a1, 64'h77A8);
    chk("R5", "small table pa", w_pa, 64'h00AB_C234);
    chk("R5", "small table flags", {52'd0, w_flags}, 64'h0A5);
  endtask

  task automatic t_root_size;
    root_ptr = 64'h1001;
    walk(64'h0112_4010, 4'd8, 1'b0, 0);
    chk("R2", "root size mask dir addr", w_a0, 64'h1000);
    chk("R2", "root size mask pa", w_pa, 64'h00AB_0000_0012_3010);
    root_ptr = 64'h100A;
  endtask

  task automatic t_backpressure;
    stall_en = 1'b1;
    walk(64'h0012_4108, 4'd8, 1'b1, 3);
    chk("R8", "stalled pa", w_pa, 64'h00AB_0000_0012_3108);
    chk("R8", "stalled reads", 64'(w_reads), 64'd2);
    chk("R10", "stalled store flag", {63'd0, w_store}, 64'd1);
    stall_en = 1'b0;
  endtask

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_empty_dir();
    t_basic();
    t_other_slot();
    t_high_bits();
    t_bad_entries();
    t_crossing();
    t_leaf_size();
    t_root_size();
    t_backpressure();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1_500_000;
    n_chk++;
    n_bad++;
    $display("FAIL R1 watchdog: actual hung expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule